// File: doc/BRIEF.md
# Width-Selectable Asynchronous SRAM Array Controller

This block lets a clocked host read and write an array of eight byte-wide asynchronous static RAM devices. The devices sit on four byte lanes. Each lane is shared by two devices, one in each of two banks. All eight devices share one device address bus, one write strobe and one output-enable strobe. Each device has its own active-low select. The width of each access is chosen per request: one byte, one halfword or one full word. The width is set only by which selects the controller pulls low. The controller splits the linear host address into a lane, a device address and a bank. It then runs the strobes for a fixed number of clock cycles. Each count is derived at elaboration from a nanosecond timing limit and the clock period.

A request is accepted with a valid/ready handshake. Read data comes back right-justified on a one-cycle pulse. The controller drives the shared data bus only while its write strobe is low. It inserts idle turnaround cycles before an access that changes the transfer direction or the bank, so that a device that is still floating its outputs never fights the next driver on the same lane.

Top module: `sram_width_ctl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `req_ready` is 1, every select is high, both strobes are high, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: Width code 00 is byte mode: address bits [1:0] give the lane, [20:2] the device address and [21] the bank. Code 01 is halfword mode: bit [0] gives the lane pair, [19:1] the device address and [20] the bank. Codes 10 and 11 are word mode: [18:0] give the device address and [19] the bank. `mem_addr` carries the device address during the access.
- R3: Select bit k (0..7) drives lane k mod 4 in bank k/4, and is active low. Byte mode pulls one select low. Halfword mode pulls two, for lanes 2p and 2p+1 where p is the pair. Word mode pulls all four of the bank. Every other select stays high.
- R4: No two selects on the same lane are low at once, and all selects are high whenever no access is in progress.
- R5: The address and select outputs do not change during an access.
- R6: A read holds `mem_oe_n` low and `mem_we_n` high for RD_CYC cycles. RD_CYC is 3 at the default 4 ns period. `rsp_valid` pulses for one cycle, RD_CYC cycles after the accepting edge, plus any turnaround.
- R7: Read data is right-justified and zero-extended. Byte mode returns the addressed lane. Halfword mode returns the addressed lane pair. Word mode returns all four lanes, with lane 0 in bits [7:0].
- R8: A write holds `mem_we_n` low for WR_CYC cycles (3 by default) with `mem_oe_n` high. `mem_dq_oe` is 1 exactly while `mem_we_n` is low. The bus carries the host byte in every lane in byte mode, the host halfword in both halves in halfword mode, and the full word in word mode.
- R9: An access whose direction or bank differs from the previous access is preceded by TURN_CYC idle cycles with all selects high. TURN_CYC is 2 by default. An access that changes neither gets none.
- R10: `req_ready` drops on the cycle after acceptance. It returns exactly turnaround + RD_CYC (read) or turnaround + WR_CYC (write) cycles after the accepting edge.
- R11: Every cycle count is ceil(limit_ns / CLK_PERIOD_NS), and at least one cycle. RD_CYC covers the read cycle, address access, select access and output-enable access limits. WR_CYC covers the write cycle, write pulse, select-to-end, address-to-end and data setup limits. TURN_CYC covers the output float limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width code: 00 byte, 01 halfword, 1x word |
| req_addr | input | 22 | Linear host address, split per width code |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 32 | Read data, right-justified |
| mem_addr | output | 19 | Shared device address |
| mem_cs_n | output | 8 | Per-device selects, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data driven onto the array bus |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 32 | Data read from the array bus |

## Verification
A read result is due RD_CYC cycles after the accepting edge, plus TURN_CYC when the direction or bank changed. The driver works out that turnaround from its own record of the previous access and queues the exact cycle number next to the expected word. The monitor then compares both the data and the arrival cycle. The return of `req_ready` is checked against the same arithmetic, using WR_CYC for writes. Strobe widths are counted on the falling clock edge: the write pulse against WR_CYC and the output-enable pulse against RD_CYC. Select pattern, address and write-bus contents are compared on every cycle of an access against values the driver derived from the address split.

// File: rtl/sram_wc_pkg.sv
`timescale 1ns/1ps
package sram_wc_pkg;

   typedef enum logic [1:0] {
      WM_BYTE = 2'b00,
      WM_HALF = 2'b01,
      WM_WORD = 2'b10,
      WM_WIDE = 2'b11
   } width_mode_e;

   function automatic int unsigned cycles_for(input int unsigned t_ns, input int unsigned per_ns);
      int unsigned c;
      if (per_ns == 0) return 1;
      c = (t_ns + per_ns - 1) / per_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wc_addr_map.sv
`timescale 1ns/1ps
module sram_wc_addr_map
   import sram_wc_pkg::*;
#(
   parameter int unsigned DEV_AW = 19,
   parameter int unsigned LANES  = 4,
   parameter int unsigned BANKS  = 2,
   localparam int unsigned LSEL_W  = $clog2(LANES),
   localparam int unsigned HOST_AW = DEV_AW + LSEL_W + 1,
   localparam int unsigned CS_W    = LANES * BANKS
) (
   input  logic [1:0]         mode,
   input  logic [HOST_AW-1:0] host_addr,
   output logic [DEV_AW-1:0]  dev_addr,
   output logic               bank,
   output logic [LSEL_W-1:0]  lane,
   output logic [CS_W-1:0]    cs_n
);

   logic [LANES-1:0] lane_mask;

   always_comb begin
      case (width_mode_e'(mode))
         WM_BYTE: begin
            lane      = host_addr[LSEL_W-1:0];
            dev_addr  = host_addr[DEV_AW+LSEL_W-1:LSEL_W];
            bank      = host_addr[HOST_AW-1];
            lane_mask = LANES'(1) << lane;
         end
         WM_HALF: begin
            lane      = {host_addr[LSEL_W-2:0], 1'b0};
            dev_addr  = host_addr[DEV_AW+LSEL_W-2:LSEL_W-1];
            bank      = host_addr[DEV_AW+LSEL_W-1];
            lane_mask = LANES'(3) << lane;
         end
         default: begin
            lane      = '0;
            dev_addr  = host_addr[DEV_AW-1:0];
            bank      = host_addr[DEV_AW];
            lane_mask = '1;
         end
      endcase
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign cs_n[b*LANES +: LANES] = (bank == 1'(b)) ? ~lane_mask : '1;
   end

   always_comb begin
      AST_ONE_BANK_ONLY: assert ((&cs_n[LANES-1:0]) || (&cs_n[CS_W-1:LANES])) // R4
         else $error("both banks selected");
   end

endmodule

// File: rtl/sram_wc_lane_mux.sv
`timescale 1ns/1ps
module sram_wc_lane_mux
   import sram_wc_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   localparam int unsigned LSEL_W = $clog2(LANES),
   localparam int unsigned DATA_W = LANE_W * LANES
) (
   input  logic [1:0]        wr_mode,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] wr_bus,
   input  logic [1:0]        rd_mode,
   input  logic [LSEL_W-1:0] rd_lane,
   input  logic [DATA_W-1:0] rd_bus,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] rep_byte, rep_half, shifted;

   for (genvar l = 0; l < LANES; l++) begin : g_rep
      assign rep_byte[l*LANE_W +: LANE_W] = wr_data[LANE_W-1:0];
      assign rep_half[l*LANE_W +: LANE_W] = wr_data[(l%2)*LANE_W +: LANE_W];
   end

   always_comb begin
      case (width_mode_e'(wr_mode))
         WM_BYTE: wr_bus = rep_byte;
         WM_HALF: wr_bus = rep_half;
         default: wr_bus = wr_data;
      endcase
   end

   assign shifted = rd_bus >> (int'(rd_lane) * LANE_W);

   always_comb begin
      case (width_mode_e'(rd_mode))
         WM_BYTE: rd_data = {{(DATA_W-LANE_W){1'b0}}, shifted[LANE_W-1:0]};
         WM_HALF: rd_data = {{(DATA_W-2*LANE_W){1'b0}}, shifted[2*LANE_W-1:0]};
         default: rd_data = shifted;
      endcase
   end

endmodule

// File: rtl/sram_wc_seq.sv
`timescale 1ns/1ps
module sram_wc_seq #(
   parameter int unsigned RD_CYC   = 3,
   parameter int unsigned WR_CYC   = 3,
   parameter int unsigned TURN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_write,
   input  logic start_bank,
   output logic idle,
   output logic in_read,
   output logic in_write,
   output logic rd_last
);

   localparam int unsigned MAXC  = (RD_CYC > WR_CYC) ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                                     : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
   localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

   typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_READ, ST_WRITE} st_e;

   st_e              st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_wr_q, last_wr_q, last_bank_q, have_last_q;
   logic             need_turn;

   assign need_turn = have_last_q && ((last_wr_q != start_write) || (last_bank_q != start_bank));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         pend_wr_q   <= 1'b0;
         last_wr_q   <= 1'b0;
         last_bank_q <= 1'b0;
         have_last_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               pend_wr_q   <= start_write;
               last_wr_q   <= start_write;
               last_bank_q <= start_bank;
               have_last_q <= 1'b1;
               if (need_turn) begin
                  st_q  <= ST_TURN;
                  cnt_q <= CNT_W'(TURN_CYC - 1);
               end else if (start_write) begin
                  st_q  <= ST_WRITE;
                  cnt_q <= CNT_W'(WR_CYC - 1);
               end else begin
                  st_q  <= ST_READ;
                  cnt_q <= CNT_W'(RD_CYC - 1);
               end
            end
            ST_TURN: begin
               if (cnt_q == '0) begin
                  st_q  <= pend_wr_q ? ST_WRITE : ST_READ;
                  cnt_q <= pend_wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) st_q  <= ST_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign idle     = (st_q == ST_IDLE);
   assign in_read  = (st_q == ST_READ);
   assign in_write = (st_q == ST_WRITE);
   assign rd_last  = in_read && (cnt_q == '0);

   AST_TURN_LEADS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TURN && cnt_q == '0) |=> (st_q == ST_READ || st_q == ST_WRITE)) // R9
      else $error("turnaround not followed by access");
   AST_READ_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_read |-> (32'(cnt_q) < RD_CYC)) // R6
      else $error("read counter out of range");
   AST_WRITE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_write |-> (32'(cnt_q) < WR_CYC)) // R8
      else $error("write counter out of range");

endmodule

// File: rtl/sram_width_ctl.sv
`timescale 1ns/1ps
module sram_width_ctl
   import sram_wc_pkg::*;
#(
   parameter int unsigned DEV_AW        = 19,
   parameter int unsigned LANE_W        = 8,
   parameter int unsigned LANES         = 4,
   parameter int unsigned BANKS         = 2,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned T_RC_NS       = 12,
   parameter int unsigned T_AA_NS       = 12,
   parameter int unsigned T_ACS_NS      = 12,
   parameter int unsigned T_OE_NS       = 6,
   parameter int unsigned T_WC_NS       = 12,
   parameter int unsigned T_WP_NS       = 10,
   parameter int unsigned T_CW_NS       = 10,
   parameter int unsigned T_AW_NS       = 10,
   parameter int unsigned T_DW_NS       = 6,
   parameter int unsigned T_HZ_NS       = 6,
   localparam int unsigned LSEL_W  = $clog2(LANES),
   localparam int unsigned HOST_AW = DEV_AW + LSEL_W + 1,
   localparam int unsigned DATA_W  = LANE_W * LANES,
   localparam int unsigned CS_W    = LANES * BANKS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [1:0]         req_mode,
   input  logic [HOST_AW-1:0] req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic [DEV_AW-1:0]  mem_addr,
   output logic [CS_W-1:0]    mem_cs_n,
   output logic               mem_we_n,
   output logic               mem_oe_n,
   output logic [DATA_W-1:0]  mem_dq_out,
   output logic               mem_dq_oe,
   input  logic [DATA_W-1:0]  mem_dq_in
);

   localparam int unsigned RD_CYC = umax(umax(cycles_for(T_RC_NS, CLK_PERIOD_NS),
                                              cycles_for(T_AA_NS, CLK_PERIOD_NS)),
                                         umax(cycles_for(T_ACS_NS, CLK_PERIOD_NS),
                                              cycles_for(T_OE_NS, CLK_PERIOD_NS)));
   localparam int unsigned WR_CYC = umax(umax(umax(cycles_for(T_WC_NS, CLK_PERIOD_NS),
                                                   cycles_for(T_WP_NS, CLK_PERIOD_NS)),
                                              umax(cycles_for(T_CW_NS, CLK_PERIOD_NS),
                                                   cycles_for(T_AW_NS, CLK_PERIOD_NS))),
                                         cycles_for(T_DW_NS, CLK_PERIOD_NS));
   localparam int unsigned TURN_CYC = cycles_for(T_HZ_NS, CLK_PERIOD_NS);

   if (LANES != 4) begin : g_bad_lanes
      $error("LANES must be 4: width codes assume byte, pair and full-word lane groups");
   end
   if (BANKS != 2) begin : g_bad_banks
      $error("BANKS must be 2: one host address bit selects the bank");
   end
   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be non-zero");
   end

   logic               accept;
   logic [DEV_AW-1:0]  dec_dev;
   logic               dec_bank;
   logic [LSEL_W-1:0]  dec_lane;
   logic [CS_W-1:0]    dec_cs_n;
   logic [DATA_W-1:0]  rep_wdata, ext_rdata;

   logic [DEV_AW-1:0]  hold_dev_q;
   logic [CS_W-1:0]    hold_cs_n_q;
   logic [LSEL_W-1:0]  hold_lane_q;
   logic [1:0]         hold_mode_q;
   logic [DATA_W-1:0]  hold_wdata_q;

   logic seq_idle, seq_read, seq_write, seq_rd_last;

   assign accept = req_valid && req_ready;

   sram_wc_addr_map #(.DEV_AW(DEV_AW), .LANES(LANES), .BANKS(BANKS)) addr_map_i (
      .mode      (req_mode),
      .host_addr (req_addr),
      .dev_addr  (dec_dev),
      .bank      (dec_bank),
      .lane      (dec_lane),
      .cs_n      (dec_cs_n)
   );

   sram_wc_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) lane_mux_i (
      .wr_mode (req_mode),
      .wr_data (req_wdata),
      .wr_bus  (rep_wdata),
      .rd_mode (hold_mode_q),
      .rd_lane (hold_lane_q),
      .rd_bus  (mem_dq_in),
      .rd_data (ext_rdata)
   );

   sram_wc_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_write (req_write),
      .start_bank  (dec_bank),
      .idle        (seq_idle),
      .in_read     (seq_read),
      .in_write    (seq_write),
      .rd_last     (seq_rd_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_dev_q   <= '0;
         hold_cs_n_q  <= '1;
         hold_lane_q  <= '0;
         hold_mode_q  <= '0;
         hold_wdata_q <= '0;
      end else if (accept) begin
         hold_dev_q   <= dec_dev;
         hold_cs_n_q  <= dec_cs_n;
         hold_lane_q  <= dec_lane;
         hold_mode_q  <= req_mode;
         hold_wdata_q <= rep_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= seq_rd_last;
         if (seq_rd_last) rsp_rdata <= ext_rdata;
      end
   end

   assign req_ready  = seq_idle;
   assign mem_addr   = hold_dev_q;
   assign mem_cs_n   = (seq_read || seq_write) ? hold_cs_n_q : '1;
   assign mem_oe_n   = ~seq_read;
   assign mem_we_n   = ~seq_write;
   assign mem_dq_oe  = seq_write;
   assign mem_dq_out = hold_wdata_q;

   // strobe-width bookkeeping for the checks below
   logic [15:0] we_run_q, oe_run_q;
   logic        we_n_q, oe_n_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run_q <= '0;
         oe_run_q <= '0;
         we_n_q   <= 1'b1;
         oe_n_q   <= 1'b1;
      end else begin
         we_n_q <= mem_we_n;
         oe_n_q <= mem_oe_n;
         if (!mem_we_n) we_run_q <= we_n_q ? 16'd1 : we_run_q + 16'd1;
         if (!mem_oe_n) oe_run_q <= oe_n_q ? 16'd1 : oe_run_q + 16'd1;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
      AST_LANE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         !(!mem_cs_n[l] && !mem_cs_n[l+LANES])) // R4
         else $error("two devices selected on one lane");
   end

   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (&mem_cs_n)) // R4
      else $error("select low while idle");
   AST_SELECT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !(&mem_cs_n) |-> ($countones(~mem_cs_n) == 1 || $countones(~mem_cs_n) == 2
                        || $countones(~mem_cs_n) == 4)) // R3
      else $error("illegal select pattern");
   AST_ACCESS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> ($stable(mem_addr) && $stable(mem_cs_n))) // R5
      else $error("address or select moved during access");
   AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && mem_oe_n)) // R8
      else $error("bus driven outside write");
   AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n)) // R6
      else $error("read and write strobes overlap");
   AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && !we_n_q) |-> (we_run_q == 16'(WR_CYC))) // R8
      else $error("write pulse width wrong");
   AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_oe_n && !oe_n_q) |-> (oe_run_q == 16'(RD_CYC))) // R6
      else $error("read strobe width wrong");
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid) // R6
      else $error("response longer than one cycle");
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready) // R10
      else $error("ready stayed high after accept");

endmodule

// File: tb/sram_width_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_width_ctl_tb_top;

   localparam int PER = 4;
   function automatic int cdiv(input int t);
      int c;
      c = (t + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   localparam int RD   = 3;   // ceil(12/4): R11
   localparam int WR   = 3;   // ceil(12/4) dominates 10 and 6: R11
   localparam int TURN = 2;   // ceil(6/4): R11

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_mode = 2'b00;
   logic [21:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [31:0] rsp_rdata, mem_dq_out;
   logic [31:0] mem_dq_in = '0;
   logic [18:0] mem_addr;
   logic [7:0]  mem_cs_n;

   sram_width_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit mon_on = 1'b0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // device array model (keyed by select index and device address)
   logic [7:0] devm [int];
   always @(negedge clk) begin : dev_model
      logic [31:0] rd;
      int key;
      rd = 32'hEEEE_EEEE;
      for (int k = 0; k < 8; k++) begin
         if (!mem_cs_n[k]) begin
            key = k * (1 << 19) + int'(mem_addr);
            if (!mem_we_n) devm[key] = mem_dq_out[(k%4)*8 +: 8];
            else if (!mem_oe_n) rd[(k%4)*8 +: 8] = devm.exists(key) ? devm[key] : 8'h00;
         end
      end
      mem_dq_in = rd;
   end

   // reference model keyed by host-visible bank, lane and device address
   logic [7:0]  refm [int];
   logic [31:0] q_data [$];
   int          q_cyc [$];
   logic [7:0]  exp_cs = 8'hFF;
   logic [18:0] exp_dev = '0;
   logic [31:0] exp_dq = '0;
   bit          have_last = 1'b0, last_wr = 1'b0;
   int          last_bank = 0;
   int          we_cnt = 0, oe_cnt = 0;

   // monitor
   always @(negedge clk) begin
      if (mon_on) begin
         for (int l = 0; l < 4; l++)
            if (!mem_cs_n[l] && !mem_cs_n[l+4])
               chk(1'b0, "R4 lane contention", 32'(mem_cs_n), 32'hFF);
         if (!(&mem_cs_n)) begin
            chk(mem_cs_n == exp_cs, "R3 select pattern", 32'(mem_cs_n), 32'(exp_cs));
            chk(mem_addr == exp_dev, "R2/R5 device address", 32'(mem_addr), 32'(exp_dev));
         end
         chk(mem_dq_oe == !mem_we_n, "R8 bus enable follows write strobe", 32'(mem_dq_oe), 32'(!mem_we_n));
         if (!mem_we_n) begin
            we_cnt++;
            chk(mem_dq_out == exp_dq, "R8 write bus data", mem_dq_out, exp_dq);
            chk(mem_oe_n, "R8 oe high during write", 32'(mem_oe_n), 32'd1);
         end else if (we_cnt != 0) begin
            chk(we_cnt == WR, "R8 write pulse width", 32'(we_cnt), 32'(WR));
            we_cnt = 0;
         end
         if (!mem_oe_n) oe_cnt++;
         else if (oe_cnt != 0) begin
            chk(oe_cnt == RD, "R6 read strobe width", 32'(oe_cnt), 32'(RD));
            oe_cnt = 0;
         end
         if (rsp_valid) begin
            if (q_data.size() == 0) chk(1'b0, "R6 unexpected response", rsp_rdata, 32'h0);
            else begin
               logic [31:0] ed;
               int ec;
               ed = q_data.pop_front();
               ec = q_cyc.pop_front();
               chk(rsp_rdata == ed, "R7 read data", rsp_rdata, ed);
               chk(cyc == ec, "R6/R9 read latency", 32'(cyc), 32'(ec));
            end
         end
      end
   end

   // driver: called at a falling edge
   task automatic do_req(input bit wr, input logic [1:0] md, input logic [21:0] a, input logic [31:0] d);
      int bank, dev, lane, nl, turn, acc, key;
      logic [31:0] e;
      case (md)
         2'b00:   begin lane = int'(a[1:0]);    dev = int'(a[20:2]); bank = int'(a[21]); nl = 1; end
         2'b01:   begin lane = int'(a[0]) * 2;  dev = int'(a[19:1]); bank = int'(a[20]); nl = 2; end
         default: begin lane = 0;               dev = int'(a[18:0]); bank = int'(a[19]); nl = 4; end
      endcase
      turn = (have_last && (last_wr != wr || last_bank != bank)) ? TURN : 0;
      have_last = 1'b1; last_wr = wr; last_bank = bank;
      exp_cs = 8'hFF;
      for (int l = 0; l < nl; l++) exp_cs[bank*4 + lane + l] = 1'b0;
      exp_dev = 19'(dev);
      e = '0;
      for (int l = 0; l < nl; l++) begin
         key = (bank*4 + lane + l) * (1 << 19) + dev;
         if (wr) refm[key] = d[l*8 +: 8];
         else e[l*8 +: 8] = refm.exists(key) ? refm[key] : 8'h00;
      end
      if (wr) exp_dq = (md == 2'b00) ? {4{d[7:0]}} : (md == 2'b01) ? {2{d[15:0]}} : d;
      req_valid = 1'b1; req_write = wr; req_mode = md; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      acc = cyc;
      req_valid = 1'b0;
      chk(!req_ready, "R10 ready drops after accept", 32'(req_ready), 32'd0);
      if (!wr) begin
         q_data.push_back(e);
         q_cyc.push_back(acc + turn + RD);
      end
      while (!req_ready) @(negedge clk);
      chk(cyc == acc + turn + (wr ? WR : RD), "R9/R10 ready return cycle",
          32'(cyc), 32'(acc + turn + (wr ? WR : RD)));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : stim
      chk(cdiv(12) == RD && cdiv(6) == TURN, "R11 count formula", 32'(cdiv(12)), 32'(RD));
      repeat (3) @(negedge clk);
      chk(req_ready && mem_cs_n == 8'hFF && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
          "R1 reset state", {mem_cs_n, 20'h0, req_ready, mem_we_n, mem_oe_n, mem_dq_oe}, {8'hFF, 20'h0, 4'b1110});
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_cs_n == 8'hFF && !rsp_valid, "R1 idle after reset",
          {mem_cs_n, 23'h0, req_ready}, {8'hFF, 23'h0, 1'b1});
      mon_on = 1'b1;
      // word write then reads of every width on the same location (R2 R3 R7)
      do_req(1'b1, 2'b10, 22'h000005, 32'hA1B2C3D4);
      do_req(1'b0, 2'b10, 22'h000005, 32'h0);          // R9 direction turn
      for (int l = 0; l < 4; l++) do_req(1'b0, 2'b00, 22'h000014 + 22'(l), 32'h0);
      do_req(1'b0, 2'b01, 22'h00000B, 32'h0);          // upper pair
      // top device address in bank 1, narrow writes (R2 R8 R9)
      do_req(1'b1, 2'b00, 22'h3FFFFE, 32'h0000005A);
      do_req(1'b1, 2'b01, 22'h1FFFFE, 32'h00001234);   // no turn expected
      do_req(1'b0, 2'b11, 22'h0FFFFF, 32'h0);          // code 11 acts as word
      do_req(1'b0, 2'b10, 22'h000005, 32'h0);          // R9 bank change only
      // replication and zero extension (R7 R8)
      do_req(1'b1, 2'b01, 22'h000006, 32'hFFFFBEEF);
      do_req(1'b1, 2'b00, 22'h00000F, 32'h12345677);
      do_req(1'b0, 2'b10, 22'h000003, 32'h0);
      do_req(1'b0, 2'b01, 22'h000006, 32'h0);
      do_req(1'b0, 2'b00, 22'h00000F, 32'h0);
      // every select individually, then both banks as words (R3 R4)
      for (int k = 0; k < 8; k++)
         do_req(1'b1, 2'b00, (22'(k/4) << 21) | 22'h000048 | 22'(k%4), 32'h10 + 32'(k));
      do_req(1'b0, 2'b10, 22'h000012, 32'h0);
      do_req(1'b0, 2'b10, 22'h080012, 32'h0);
      do_req(1'b0, 2'b01, 22'h100025, 32'h0);
      repeat (10) @(negedge clk);
      chk(q_data.size() == 0, "R6 all responses arrived", 32'(q_data.size()), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule